// File: doc/BRIEF.md
# Row Checksum and Parity Error Controller

This controller sits between a host and a group of `N_DATA` data memory chips plus one parity chip. Every row a chip stores is kept alongside a 16-bit checksum, so a chip can prove its own row intact on a single read. The parity chip holds, for each row address, the bitwise XOR of that row across all data chips. Together they form a two-tier scheme: the checksum spots a bad row, and the parity rebuilds it.

The host issues a whole-row read or write to one data chip at a time. A clean read costs one array access. A write fetches the old data and the old parity, then stores the new data and the patched parity. If a checksum does not match, the controller walks the remaining chips of that row and rebuilds the lost content from them. A second fault in the same row is reported as uncorrectable.

The controller takes one host request at a time. Because of this, no two write sequences can ever overlap on the same parity row. The array side uses a valid/ready command channel, and read data comes back on a separate valid strobe.

Top module: `row_guard_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `arr_cmd_valid` is 0.
- R2: Every array write carries `arr_cmd_wcsum` equal to the 16-bit ones'-complement sum, with end-around carry, of the row's 16-bit words (word 0 in bits [15:0]). An all-zero row sums to 0.
- R3: A host read whose chip row passes its checksum issues exactly one array read, to the addressed chip. It returns that row with both `rsp_corrected` and `rsp_uncorr` clear. Chips other than the addressed one are not touched, so a corrupted neighbour has no effect on the read.
- R4: A clean host write issues exactly four array commands, in this order: read of the target chip, read of the parity chip (index `N_DATA`), write of the target chip, write of the parity chip. The new parity equals old parity XOR old data XOR new data.
- R5: When the addressed row fails its checksum on a read, the controller reads the same row from every other data chip in ascending index order, then from the parity chip. It returns their XOR with `rsp_corrected` = 1. That makes `N_DATA`+1 array reads in total.
- R6: If any row read during a rebuild, including the parity row, also fails its checksum, the response has `rsp_uncorr` = 1, `rsp_corrected` = 0 and `rsp_rdata` = 0.
- R7: When the old data fails its checksum during a write, the controller rebuilds the old data from the other chips and the parity, then completes both writes with `rsp_corrected` = 1. That makes `N_DATA`+1 reads and 2 writes. Afterwards the stored data, its checksum and the parity are all consistent again.
- R8: When the old parity fails its checksum during a write, the response has `rsp_uncorr` = 1 and no array write is issued, so the target row keeps its old contents.
- R9: `req_ready` stays low from the cycle after a request is accepted until the response has been given. It returns high in the cycle after `rsp_valid`. An array command that is not accepted is held unchanged.
- R10: `rsp_valid` is a one-cycle pulse, and `rsp_corrected` and `rsp_uncorr` are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_chip | input | CHIP_W | Target data chip, below N_DATA |
| req_row | input | ROW_AW | Row address |
| req_wdata | input | ROW_BITS | Row to write |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | ROW_BITS | Read result (0 for writes and uncorrectable reads) |
| rsp_corrected | output | 1 | Data was rebuilt from parity |
| rsp_uncorr | output | 1 | Double fault, data lost or write refused |
| arr_cmd_valid | output | 1 | Array command present |
| arr_cmd_ready | input | 1 | Array accepts the command |
| arr_cmd_we | output | 1 | 1 = array write, 0 = array read |
| arr_cmd_chip | output | CHIP_W | Chip index; N_DATA selects the parity chip |
| arr_cmd_row | output | ROW_AW | Row address |
| arr_cmd_wdata | output | ROW_BITS | Row to store |
| arr_cmd_wcsum | output | 16 | Checksum to store with the row |
| arr_rsp_valid | input | 1 | Array read data present |
| arr_rsp_rdata | input | ROW_BITS | Row read from the array |
| arr_rsp_rcsum | input | 16 | Checksum stored with that row |

## Verification
The checker takes for granted that the host names only chips below `N_DATA` and that the array returns exactly one `arr_rsp_valid` pulse for each accepted read and none otherwise. The ordering and hold properties depend on those two conditions. The bench's array model keeps `arr_cmd_ready` high and answers every accepted read one cycle later. Its host tasks raise `req_valid` only while `req_ready` is high. Faults are injected by flipping stored data bits while leaving the stored checksum alone, and this is done only between requests.

// File: rtl/row_guard_pkg.sv
package row_guard_pkg;

   localparam int CSUM_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_WR_REQ,
      ST_RESP
   } seq_state_e;

   typedef enum logic [2:0] {
      PH_PRIM,
      PH_PAR,
      PH_SWEEP,
      PH_WDATA,
      PH_WPAR
   } seq_phase_e;

   // one step of a ones'-complement sum: add, then fold the carry back in
   function automatic logic [CSUM_W-1:0] oc_add(input logic [CSUM_W-1:0] a,
                                                input logic [CSUM_W-1:0] b);
      logic [CSUM_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, s[CSUM_W]};
   endfunction

endpackage

// File: rtl/rg_csum_unit.sv
module rg_csum_unit
   import row_guard_pkg::*;
#(
   parameter int ROW_WORDS = 4,
   localparam int ROW_BITS = ROW_WORDS * CSUM_W
) (
   input  logic [ROW_BITS-1:0] row_i,
   output logic [CSUM_W-1:0]   sum_o
);

   logic [CSUM_W-1:0] part [ROW_WORDS+1];

   assign part[0] = '0;

   for (genvar w = 0; w < ROW_WORDS; w++) begin : g_word
      assign part[w+1] = oc_add(part[w], row_i[w*CSUM_W +: CSUM_W]);
   end

   assign sum_o = part[ROW_WORDS];

endmodule

// File: rtl/rg_seq.sv
module rg_seq
   import row_guard_pkg::*;
#(
   parameter int N_DATA   = 4,
   parameter int CHIP_W   = 3,
   parameter int ROW_AW   = 4,
   parameter int ROW_BITS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_we,
   input  logic [CHIP_W-1:0]   req_chip,
   input  logic [ROW_AW-1:0]   req_row,
   input  logic [ROW_BITS-1:0] req_wdata,
   output logic                rsp_valid,
   output logic [ROW_BITS-1:0] rsp_rdata,
   output logic                rsp_corrected,
   output logic                rsp_uncorr,
   output logic                cmd_valid,
   input  logic                cmd_ready,
   output logic                cmd_we,
   output logic [CHIP_W-1:0]   cmd_chip,
   output logic [ROW_AW-1:0]   cmd_row,
   output logic [ROW_BITS-1:0] cmd_wdata,
   input  logic                rd_valid,
   input  logic [ROW_BITS-1:0] rd_data,
   input  logic                rd_ok
);

   localparam logic [CHIP_W-1:0] PAR_IDX = CHIP_W'(N_DATA);

   seq_state_e          state;
   seq_phase_e          phase;
   logic                op_we;
   logic [CHIP_W-1:0]   tgt;
   logic [CHIP_W-1:0]   cur;
   logic [ROW_AW-1:0]   row_q;
   logic [ROW_BITS-1:0] new_q;
   logic [ROW_BITS-1:0] old_q;
   logic [ROW_BITS-1:0] par_q;
   logic [ROW_BITS-1:0] acc_q;
   logic [ROW_BITS-1:0] res_q;
   logic                corr_q;
   logic                unc_q;

   // next chip of a rebuild walk, stepping over the failed target
   function automatic logic [CHIP_W-1:0] walk_next(input logic [CHIP_W-1:0] c,
                                                   input logic [CHIP_W-1:0] t);
      logic [CHIP_W-1:0] n;
      n = c + 1'b1;
      if (n == t) n = n + 1'b1;
      return n;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         phase  <= PH_PRIM;
         op_we  <= 1'b0;
         tgt    <= '0;
         cur    <= '0;
         row_q  <= '0;
         new_q  <= '0;
         old_q  <= '0;
         par_q  <= '0;
         acc_q  <= '0;
         res_q  <= '0;
         corr_q <= 1'b0;
         unc_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  op_we  <= req_we;
                  tgt    <= req_chip;
                  cur    <= req_chip;
                  row_q  <= req_row;
                  new_q  <= req_wdata;
                  res_q  <= '0;
                  acc_q  <= '0;
                  corr_q <= 1'b0;
                  unc_q  <= 1'b0;
                  phase  <= PH_PRIM;
                  state  <= ST_RD_REQ;
               end
            end
            ST_RD_REQ: begin
               if (cmd_ready) state <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (rd_valid) begin
                  unique case (phase)
                     PH_PRIM: begin
                        if (rd_ok) begin
                           if (op_we) begin
                              old_q <= rd_data;
                              cur   <= PAR_IDX;
                              phase <= PH_PAR;
                              state <= ST_RD_REQ;
                           end else begin
                              res_q <= rd_data;
                              state <= ST_RESP;
                           end
                        end else begin
                           acc_q <= '0;
                           cur   <= (tgt == '0) ? CHIP_W'(1) : '0;
                           phase <= PH_SWEEP;
                           state <= ST_RD_REQ;
                        end
                     end
                     PH_PAR: begin
                        if (rd_ok) begin
                           par_q <= rd_data;
                           cur   <= tgt;
                           phase <= PH_WDATA;
                           state <= ST_WR_REQ;
                        end else begin
                           unc_q <= 1'b1;
                           state <= ST_RESP;
                        end
                     end
                     PH_SWEEP: begin
                        if (!rd_ok) begin
                           unc_q <= 1'b1;
                           res_q <= '0;
                           state <= ST_RESP;
                        end else if (cur == PAR_IDX) begin
                           corr_q <= 1'b1;
                           par_q  <= rd_data;
                           if (op_we) begin
                              old_q <= acc_q ^ rd_data;
                              cur   <= tgt;
                              phase <= PH_WDATA;
                              state <= ST_WR_REQ;
                           end else begin
                              res_q <= acc_q ^ rd_data;
                              state <= ST_RESP;
                           end
                        end else begin
                           acc_q <= acc_q ^ rd_data;
                           cur   <= walk_next(cur, tgt);
                           state <= ST_RD_REQ;
                        end
                     end
                     default: state <= ST_RESP;
                  endcase
               end
            end
            ST_WR_REQ: begin
               if (cmd_ready) begin
                  if (phase == PH_WDATA) begin
                     phase <= PH_WPAR;
                     cur   <= PAR_IDX;
                  end else begin
                     state <= ST_RESP;
                  end
               end
            end
            ST_RESP: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == ST_IDLE);
   assign rsp_valid     = (state == ST_RESP);
   assign rsp_rdata     = res_q;
   assign rsp_corrected = corr_q;
   assign rsp_uncorr    = unc_q;

   assign cmd_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
   assign cmd_we    = (state == ST_WR_REQ);
   assign cmd_chip  = cur;
   assign cmd_row   = row_q;
   assign cmd_wdata = (phase == PH_WPAR) ? (par_q ^ old_q ^ new_q) : new_q;

endmodule

// File: rtl/row_guard_ctrl.sv
module row_guard_ctrl
   import row_guard_pkg::*;
#(
   parameter int N_DATA    = 4,
   parameter int ROW_WORDS = 4,
   parameter int ROW_AW    = 4,
   parameter bit REG_RSP   = 1'b0,
   localparam int CHIP_W   = $clog2(N_DATA + 1),
   localparam int ROW_BITS = ROW_WORDS * CSUM_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_we,
   input  logic [CHIP_W-1:0]   req_chip,
   input  logic [ROW_AW-1:0]   req_row,
   input  logic [ROW_BITS-1:0] req_wdata,
   output logic                rsp_valid,
   output logic [ROW_BITS-1:0] rsp_rdata,
   output logic                rsp_corrected,
   output logic                rsp_uncorr,
   output logic                arr_cmd_valid,
   input  logic                arr_cmd_ready,
   output logic                arr_cmd_we,
   output logic [CHIP_W-1:0]   arr_cmd_chip,
   output logic [ROW_AW-1:0]   arr_cmd_row,
   output logic [ROW_BITS-1:0] arr_cmd_wdata,
   output logic [CSUM_W-1:0]   arr_cmd_wcsum,
   input  logic                arr_rsp_valid,
   input  logic [ROW_BITS-1:0] arr_rsp_rdata,
   input  logic [CSUM_W-1:0]   arr_rsp_rcsum
);

   if (N_DATA < 2) begin : g_bad_ndata
      $error("row_guard_ctrl: N_DATA must be at least 2");
   end
   if (ROW_WORDS < 1) begin : g_bad_words
      $error("row_guard_ctrl: ROW_WORDS must be at least 1");
   end
   if (ROW_AW < 1) begin : g_bad_aw
      $error("row_guard_ctrl: ROW_AW must be at least 1");
   end

   logic                stg_valid;
   logic [ROW_BITS-1:0] stg_data;
   logic [CSUM_W-1:0]   stg_csum;
   logic [CSUM_W-1:0]   rd_sum;
   logic                rd_ok;

   if (REG_RSP) begin : g_rsp_reg
      logic                v_q;
      logic [ROW_BITS-1:0] d_q;
      logic [CSUM_W-1:0]   c_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
            c_q <= '0;
         end else begin
            v_q <= arr_rsp_valid;
            d_q <= arr_rsp_rdata;
            c_q <= arr_rsp_rcsum;
         end
      end
      assign stg_valid = v_q;
      assign stg_data  = d_q;
      assign stg_csum  = c_q;
   end else begin : g_rsp_pass
      assign stg_valid = arr_rsp_valid;
      assign stg_data  = arr_rsp_rdata;
      assign stg_csum  = arr_rsp_rcsum;
   end

   rg_csum_unit #(.ROW_WORDS(ROW_WORDS)) u_rd_sum (
      .row_i (stg_data),
      .sum_o (rd_sum)
   );

   assign rd_ok = (rd_sum == stg_csum);

   rg_csum_unit #(.ROW_WORDS(ROW_WORDS)) u_wr_sum (
      .row_i (arr_cmd_wdata),
      .sum_o (arr_cmd_wcsum)
   );

   rg_seq #(
      .N_DATA   (N_DATA),
      .CHIP_W   (CHIP_W),
      .ROW_AW   (ROW_AW),
      .ROW_BITS (ROW_BITS)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_we        (req_we),
      .req_chip      (req_chip),
      .req_row       (req_row),
      .req_wdata     (req_wdata),
      .rsp_valid     (rsp_valid),
      .rsp_rdata     (rsp_rdata),
      .rsp_corrected (rsp_corrected),
      .rsp_uncorr    (rsp_uncorr),
      .cmd_valid     (arr_cmd_valid),
      .cmd_ready     (arr_cmd_ready),
      .cmd_we        (arr_cmd_we),
      .cmd_chip      (arr_cmd_chip),
      .cmd_row       (arr_cmd_row),
      .cmd_wdata     (arr_cmd_wdata),
      .rd_valid      (stg_valid),
      .rd_data       (stg_data),
      .rd_ok         (rd_ok)
   );

endmodule

// File: rtl/rg_ctrl_chk.sv
module rg_ctrl_chk #(
   parameter int N_DATA = 4,
   parameter int CHIP_W = 3,
   parameter int ROW_AW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [CHIP_W-1:0] req_chip,
   input logic              rsp_valid,
   input logic              rsp_corrected,
   input logic              rsp_uncorr,
   input logic              arr_cmd_valid,
   input logic              arr_cmd_ready,
   input logic              arr_cmd_we,
   input logic [CHIP_W-1:0] arr_cmd_chip,
   input logic [ROW_AW-1:0] arr_cmd_row
);

   localparam logic [CHIP_W-1:0] PAR_IDX = CHIP_W'(N_DATA);

   // R3
   req_chip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (req_chip < PAR_IDX));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !arr_cmd_valid);

   // R5
   cmd_chip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_cmd_valid |-> (arr_cmd_chip <= PAR_IDX));

   // R4
   par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_cmd_valid && arr_cmd_ready && arr_cmd_we && (arr_cmd_chip != PAR_IDX))
      |=> (arr_cmd_valid && arr_cmd_we && (arr_cmd_chip == PAR_IDX)));

   // R9
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_cmd_valid && !arr_cmd_ready) |=>
      (arr_cmd_valid && $stable(arr_cmd_chip) && $stable(arr_cmd_we) && $stable(arr_cmd_row)));

   // R10
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R10
   rsp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_corrected && rsp_uncorr));

endmodule

bind row_guard_ctrl rg_ctrl_chk #(
   .N_DATA (N_DATA),
   .CHIP_W (CHIP_W),
   .ROW_AW (ROW_AW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_chip      (req_chip),
   .rsp_valid     (rsp_valid),
   .rsp_corrected (rsp_corrected),
   .rsp_uncorr    (rsp_uncorr),
   .arr_cmd_valid (arr_cmd_valid),
   .arr_cmd_ready (arr_cmd_ready),
   .arr_cmd_we    (arr_cmd_we),
   .arr_cmd_chip  (arr_cmd_chip),
   .arr_cmd_row   (arr_cmd_row)
);

// File: tb/row_guard_ctrl_tb.sv
`timescale 1ns/1ps
module row_guard_ctrl_tb;

   localparam int ND  = 4;
   localparam int RB  = 64;
   localparam int NR  = 16;

   typedef struct packed {
      logic        we;
      logic [2:0]  chip;
      logic [3:0]  row;
      logic [2:0]  inj;
      logic        corr;
      logic [63:0] data;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 3'd0, 4'd1, 3'd7, 1'b0, 64'h0123_4567_89AB_CDEF},
      '{1'b1, 3'd1, 4'd1, 3'd7, 1'b0, 64'hFFFF_FFFF_0001_8000},
      '{1'b1, 3'd2, 4'd1, 3'd7, 1'b0, 64'h8000_8000_8000_8000},
      '{1'b1, 3'd3, 4'd1, 3'd7, 1'b0, 64'h0F0F_F0F0_AAAA_5555},
      '{1'b0, 3'd2, 4'd1, 3'd7, 1'b0, 64'h0},
      '{1'b0, 3'd1, 4'd1, 3'd1, 1'b1, 64'h0},
      '{1'b1, 3'd1, 4'd1, 3'd7, 1'b1, 64'h1357_9BDF_2468_ACE0},
      '{1'b0, 3'd1, 4'd1, 3'd7, 1'b0, 64'h0},
      '{1'b1, 3'd0, 4'd2, 3'd7, 1'b0, 64'hDEAD_BEEF_CAFE_F00D},
      '{1'b0, 3'd3, 4'd2, 3'd0, 1'b0, 64'h0},
      '{1'b1, 3'd0, 4'd2, 3'd7, 1'b1, 64'h7FFF_0000_FFFF_0001},
      '{1'b0, 3'd0, 4'd2, 3'd7, 1'b0, 64'h0},
      '{1'b0, 3'd3, 4'd1, 3'd4, 1'b0, 64'h0}
   };

   localparam logic [63:0] FLIP = 64'h0000_0100_0000_0001;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_we = 1'b0;
   logic [2:0]    req_chip = '0;
   logic [3:0]    req_row = '0;
   logic [RB-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [RB-1:0] rsp_rdata;
   logic          rsp_corrected;
   logic          rsp_uncorr;
   logic          arr_cmd_valid;
   logic          arr_cmd_ready;
   logic          arr_cmd_we;
   logic [2:0]    arr_cmd_chip;
   logic [3:0]    arr_cmd_row;
   logic [RB-1:0] arr_cmd_wdata;
   logic [15:0]   arr_cmd_wcsum;
   logic          arr_rsp_valid;
   logic [RB-1:0] arr_rsp_rdata;
   logic [15:0]   arr_rsp_rcsum;

   always #2.5 clk = ~clk;

   row_guard_ctrl u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_we        (req_we),
      .req_chip      (req_chip),
      .req_row       (req_row),
      .req_wdata     (req_wdata),
      .rsp_valid     (rsp_valid),
      .rsp_rdata     (rsp_rdata),
      .rsp_corrected (rsp_corrected),
      .rsp_uncorr    (rsp_uncorr),
      .arr_cmd_valid (arr_cmd_valid),
      .arr_cmd_ready (arr_cmd_ready),
      .arr_cmd_we    (arr_cmd_we),
      .arr_cmd_chip  (arr_cmd_chip),
      .arr_cmd_row   (arr_cmd_row),
      .arr_cmd_wdata (arr_cmd_wdata),
      .arr_cmd_wcsum (arr_cmd_wcsum),
      .arr_rsp_valid (arr_rsp_valid),
      .arr_rsp_rdata (arr_rsp_rdata),
      .arr_rsp_rcsum (arr_rsp_rcsum)
   );

   // array model: always ready, read data one cycle after acceptance
   logic [RB-1:0] mem_data [ND+1][NR];
   logic [15:0]   mem_csum [ND+1][NR];
   logic [2:0]    log_sel [256];
   logic          log_we  [256];
   int            log_cnt;
   logic          inj_en = 1'b0;
   logic [2:0]    inj_chip = '0;
   logic [3:0]    inj_row = '0;

   assign arr_cmd_ready = 1'b1;

   always @(posedge clk) begin
      if (!rst_n) begin
         arr_rsp_valid <= 1'b0;
         arr_rsp_rdata <= '0;
         arr_rsp_rcsum <= '0;
         log_cnt       <= 0;
         for (int c = 0; c <= ND; c++)
            for (int r = 0; r < NR; r++) begin
               mem_data[c][r] <= '0;
               mem_csum[c][r] <= '0;
            end
      end else begin
         arr_rsp_valid <= 1'b0;
         if (inj_en) mem_data[inj_chip][inj_row] <= mem_data[inj_chip][inj_row] ^ FLIP;
         if (arr_cmd_valid) begin
            log_sel[log_cnt[7:0]] <= arr_cmd_chip;
            log_we[log_cnt[7:0]]  <= arr_cmd_we;
            log_cnt <= log_cnt + 1;
            if (arr_cmd_we) begin
               mem_data[arr_cmd_chip][arr_cmd_row] <= arr_cmd_wdata;
               mem_csum[arr_cmd_chip][arr_cmd_row] <= arr_cmd_wcsum;
            end else begin
               arr_rsp_valid <= 1'b1;
               arr_rsp_rdata <= mem_data[arr_cmd_chip][arr_cmd_row];
               arr_rsp_rcsum <= mem_csum[arr_cmd_chip][arr_cmd_row];
            end
         end
      end
   end

   int n_tests = 0;
   int n_fail  = 0;
   int busy_err = 0;
   int pulse_err = 0;
   logic [RB-1:0] shadow [ND][NR];

   function automatic logic [15:0] ref_sum(input logic [RB-1:0] d);
      int s;
      s = 0;
      for (int w = 0; w < RB/16; w++) s += int'(d[w*16 +: 16]);
      while (s > 32'h0000_FFFF) s = (s & 32'h0000_FFFF) + (s >>> 16);
      return s[15:0];
   endfunction

   function automatic logic [RB-1:0] ref_par(input int row);
      logic [RB-1:0] p;
      p = '0;
      for (int c = 0; c < ND; c++) p ^= shadow[c][row];
      return p;
   endfunction

   task automatic check(input logic ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic inject(input logic [2:0] c, input logic [3:0] r);
      @(negedge clk);
      inj_en = 1'b1; inj_chip = c; inj_row = r;
      @(negedge clk);
      inj_en = 1'b0;
   endtask

   task automatic do_op(input logic we, input logic [2:0] c, input logic [3:0] r,
                        input logic [63:0] d, output logic [63:0] rd,
                        output logic corr, output logic unc);
      int guard;
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_chip = c; req_row = r; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (!rsp_valid && guard < 2000) begin
         if (req_ready) busy_err++;
         @(negedge clk);
         guard++;
      end
      if (guard >= 2000) begin
         n_tests++; n_fail++;
         $display("FAIL R9 no response actual=%0d expected=<2000", guard);
      end
      rd = rsp_rdata; corr = rsp_corrected; unc = rsp_uncorr;
      @(negedge clk);
      if (rsp_valid || !req_ready) pulse_err++;
   endtask

   initial begin
      #900us;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] rd;
      logic        corr, unc;
      int          start, ncmd;
      for (int c = 0; c < ND; c++)
         for (int r = 0; r < NR; r++) shadow[c][r] = '0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
      check(rsp_valid == 1'b0, "R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
      check(arr_cmd_valid == 1'b0, "R1 arr_cmd_valid after reset", {63'd0, arr_cmd_valid}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].inj != 3'd7) inject(VEC[i].inj, VEC[i].row);
         start = log_cnt;
         do_op(VEC[i].we, VEC[i].chip, VEC[i].row, VEC[i].data, rd, corr, unc);
         ncmd = log_cnt - start;
         check(corr == VEC[i].corr, $sformatf("R5/R7 corrected flag vec %0d", i),
               {63'd0, corr}, {63'd0, VEC[i].corr});
         check(unc == 1'b0, $sformatf("R6 uncorr flag vec %0d", i), {63'd0, unc}, 64'd0);
         if (!VEC[i].we) begin
            check(rd == shadow[VEC[i].chip][VEC[i].row], $sformatf("R3/R5 read data vec %0d", i),
                  rd, shadow[VEC[i].chip][VEC[i].row]);
            check(ncmd == (VEC[i].corr ? ND + 1 : 1), $sformatf("R3/R5 read count vec %0d", i),
                  64'(ncmd), 64'(VEC[i].corr ? ND + 1 : 1));
            check(log_sel[start[7:0]] == VEC[i].chip, $sformatf("R3 first chip vec %0d", i),
                  64'(log_sel[start[7:0]]), 64'(VEC[i].chip));
         end else begin
            shadow[VEC[i].chip][VEC[i].row] = VEC[i].data;
            check(ncmd == (VEC[i].corr ? ND + 3 : 4), $sformatf("R4/R7 write count vec %0d", i),
                  64'(ncmd), 64'(VEC[i].corr ? ND + 3 : 4));
            if (!VEC[i].corr)
               check(log_sel[start[7:0]] == VEC[i].chip && !log_we[start[7:0]] &&
                     log_sel[8'(start+1)] == 3'(ND) && !log_we[8'(start+1)] &&
                     log_sel[8'(start+2)] == VEC[i].chip && log_we[8'(start+2)] &&
                     log_sel[8'(start+3)] == 3'(ND) && log_we[8'(start+3)],
                     $sformatf("R4 command order vec %0d", i),
                     {56'd0, log_sel[8'(start+2)], log_sel[8'(start+3)], 2'd0}, {56'd0, VEC[i].chip, 3'(ND), 2'd0});
            check(mem_data[VEC[i].chip][VEC[i].row] == VEC[i].data, $sformatf("R4 stored data vec %0d", i),
                  mem_data[VEC[i].chip][VEC[i].row], VEC[i].data);
            check(mem_csum[VEC[i].chip][VEC[i].row] == ref_sum(VEC[i].data), $sformatf("R2 data checksum vec %0d", i),
                  64'(mem_csum[VEC[i].chip][VEC[i].row]), 64'(ref_sum(VEC[i].data)));
            check(mem_data[ND][VEC[i].row] == ref_par(VEC[i].row), $sformatf("R4/R7 parity vec %0d", i),
                  mem_data[ND][VEC[i].row], ref_par(VEC[i].row));
            check(mem_csum[ND][VEC[i].row] == ref_sum(ref_par(VEC[i].row)), $sformatf("R2 parity checksum vec %0d", i),
                  64'(mem_csum[ND][VEC[i].row]), 64'(ref_sum(ref_par(VEC[i].row))));
         end
      end

      // R6: target and parity both bad
      inject(3'd2, 4'd7);
      inject(3'd4, 4'd7);
      do_op(1'b0, 3'd2, 4'd7, 64'd0, rd, corr, unc);
      check(unc == 1'b1 && corr == 1'b0, "R6 parity also bad flags", {62'd0, unc, corr}, 64'd2);
      check(rd == 64'd0, "R6 parity also bad data", rd, 64'd0);

      // R6: two data chips bad
      inject(3'd0, 4'd8);
      inject(3'd1, 4'd8);
      do_op(1'b0, 3'd0, 4'd8, 64'd0, rd, corr, unc);
      check(unc == 1'b1 && corr == 1'b0, "R6 two data chips bad flags", {62'd0, unc, corr}, 64'd2);

      // R8: bad parity on write, no array writes
      inject(3'd4, 4'd9);
      start = log_cnt;
      do_op(1'b1, 3'd3, 4'd9, 64'hAAAA_BBBB_CCCC_DDDD, rd, corr, unc);
      ncmd = log_cnt - start;
      check(unc == 1'b1 && corr == 1'b0, "R8 write bad parity flags", {62'd0, unc, corr}, 64'd2);
      check(ncmd == 2 && !log_we[start[7:0]] && !log_we[8'(start+1)], "R8 no array write",
            64'(ncmd), 64'd2);
      do_op(1'b0, 3'd3, 4'd9, 64'd0, rd, corr, unc);
      check(rd == 64'd0 && !unc, "R8 target row unchanged", rd, 64'd0);

      check(busy_err == 0, "R9 req_ready low while busy", 64'(busy_err), 64'd0);
      check(pulse_err == 0, "R10 single-cycle rsp_valid", 64'(pulse_err), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule